// File: doc/BRIEF.md
# Cartridge ROM Bank Mapper with Save-RAM Protection

This block sits on the cartridge side of a 68000-style host bus and stretches a 4 MB window of CPU address space over a ROM of up to 32 MB. The CPU window is cut into eight 512 KB slots. Slot 0 always shows ROM page 0, so the reset vectors stay in view. Slots 1 to 7 each take a 6-bit page number from a register that the host writes through the cartridge I/O strobe region. The translated ROM word address is the slot's page number placed above CPU address bits A18..A1.

A control register in the same region holds two bits. The enable bit hands the save-RAM slot (byte range 0x200000 to 0x27FFFF) from the ROM to the battery-backed SRAM. The protect bit keeps the SRAM readable but drops every write strobe to it. Register writes at offsets that decode to nothing leave all state unchanged. A cartridge built without the mapper can therefore take the same writes without harm. Parameters remove the paging or the protect function, and a cartridge built that way also ignores the related writes.

The outputs are the ROM address and select, and the SRAM address, select and write enable. These decode from the live CPU inputs and the stored register state, with no pipeline delay. A register write takes effect at the clock edge that captures it.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, slot n maps to page n for every slot, and the save-RAM enable and write-protect bits are both clear, so every slot reads ROM.
- R2: A write to I/O offset 0xF1 loads data bit 0 as the save-RAM enable and data bit 1 as the write-protect bit. Data bits 7..2 are ignored.
- R3: A write to offset 0xF1 + 2n (n = 1..7, that is 0xF3 through 0xFF) loads data bits 5..0 as the page of slot n. The new page applies to accesses from the next clock cycle onward.
- R4: The slot is CPU address bits A21..A19, and rom_addr equals {page, A18..A1}. Slot 0 always uses page 0.
- R5: When the enable bit is set, a read or write in slot 4 asserts sram_cs and does not assert rom_cs. In that case sram_addr carries A15..A1.
- R6: While the write-protect bit is set, sram_we stays low, but reads of the save-RAM slot still assert sram_cs.
- R7: Writes to even offsets, or to offsets outside 0xF1..0xFF, change no page and no control bit.
- R8: rom_cs is asserted only for a read outside an enabled save-RAM slot. A write to ROM space asserts no select.
- R9: An access in the same cycle as a register write decodes with the register's old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | One-cycle write strobe into the cartridge I/O region |
| io_ofs | input | 8 | Byte offset within the I/O region |
| io_data | input | 8 | Write data for the I/O region |
| cpu_as | input | 1 | Memory access valid |
| cpu_we | input | 1 | Memory access is a write |
| cpu_addr | input | 21 | CPU word address A21..A1 |
| rom_addr | output | 24 | Translated ROM word address A24..A1 |
| rom_cs | output | 1 | ROM select |
| sram_addr | output | 15 | SRAM word address A15..A1 |
| sram_cs | output | 1 | SRAM select |
| sram_we | output | 1 | SRAM write enable |

## Verification
A register write and a memory access can land in the same cycle, and each then has to follow its own timing. The bench raises a write to the slot-2 page register while a read of slot 2 is held. It also changes the protect bit while an SRAM write is held. The outputs are sampled twice: shortly after the falling edge, where the old page and the old protect state must still apply, and shortly after the capturing rising edge, where the new values must apply.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

   typedef struct packed {
      logic ram_en;
      logic wprot;
   } cbm_ctrl_t;

   typedef enum logic [1:0] {
      RGN_IDLE = 2'd0,
      RGN_ROM  = 2'd1,
      RGN_SRAM = 2'd2,
      RGN_DROP = 2'd3
   } cbm_region_e;

endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
   import cbm_pkg::*;
#(
   parameter int         PAGE_W       = 6,
   parameter int         NUM_SLOTS    = 8,
   parameter logic [7:0] REG_BASE     = 8'hF1,
   parameter bit         HAS_PAGING   = 1'b1,
   parameter bit         HAS_WPROTECT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          io_wr,
   input  logic [7:0]                    io_ofs,
   input  logic [7:0]                    io_data,
   output cbm_ctrl_t                     ctrl,
   output logic [NUM_SLOTS*PAGE_W-1:0]   page_flat
);

   localparam int SLOT_IW  = $clog2(NUM_SLOTS);
   localparam int LAST_OFS = int'(REG_BASE) + 2 * (NUM_SLOTS - 1);

   if (NUM_SLOTS < 2 || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("cbm_regs: NUM_SLOTS must be a power of two of at least 2");
   end
   if (LAST_OFS > 255) begin : g_bad_base
      $error("cbm_regs: page registers run past the I/O byte range");
   end
   if (PAGE_W < SLOT_IW || PAGE_W > 8) begin : g_bad_page
      $error("cbm_regs: PAGE_W must hold a slot index and fit the data byte");
   end

   logic hit_ctrl;
   assign hit_ctrl = io_wr && (io_ofs == REG_BASE);

   // save-RAM enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl.ram_en <= 1'b0;
      else if (hit_ctrl) ctrl.ram_en <= io_data[0];
   end

   // write-protect bit: stored, or tied off when the option is absent
   if (HAS_WPROTECT) begin : g_wprot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ctrl.wprot <= 1'b0;
         else if (hit_ctrl) ctrl.wprot <= io_data[1];
      end
   end else begin : g_no_wprot
      assign ctrl.wprot = 1'b0;
   end

   // page registers, one per slot; slot 0 hard-wired
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int         OFS_I  = int'(REG_BASE) + 2 * s;
      localparam logic [7:0] MY_OFS = OFS_I[7:0];
      logic [PAGE_W-1:0] page_q;

      if (s == 0) begin : g_fixed
         assign page_q = '0;
      end else if (HAS_PAGING) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               page_q <= PAGE_W'(s);
            else if (io_wr && io_ofs == MY_OFS)
               page_q <= io_data[PAGE_W-1:0];
         end
         // R3: the register holds exactly the written low bits one cycle later
         a_r3_page_load: assert property (@(posedge clk) disable iff (!rst_n)
            (io_wr && io_ofs == MY_OFS) |=> (page_q == $past(io_data[PAGE_W-1:0])));
      end else begin : g_ident
         assign page_q = PAGE_W'(s);
      end

      assign page_flat[s*PAGE_W +: PAGE_W] = page_q;
   end

   logic unused_data_hi;
   assign unused_data_hi = ^io_data;

   // independent decode of "some register was addressed", used only by checks
   logic any_hit;
   assign any_hit = (int'(io_ofs) >= int'(REG_BASE)) && (int'(io_ofs) <= LAST_OFS) &&
                    (io_ofs[0] == REG_BASE[0]);

   // R2: control bits follow data bits 0 and 1 after a control write
   a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl |=> (ctrl.ram_en == $past(io_data[0])) &&
                   (!HAS_WPROTECT || ctrl.wprot == $past(io_data[1])));

   // R7: a write that decodes to no register leaves every register alone
   a_r7_ignore_stray: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !any_hit) |=> ($stable(page_flat) && $stable(ctrl)));

endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate #(
   parameter int PAGE_W    = 6,
   parameter int NUM_SLOTS = 8,
   parameter int SLOT_AW   = 18
) (
   input  logic [SLOT_AW+$clog2(NUM_SLOTS)-1:0] cpu_addr,
   input  logic [NUM_SLOTS*PAGE_W-1:0]          page_flat,
   output logic [$clog2(NUM_SLOTS)-1:0]         slot,
   output logic [PAGE_W+SLOT_AW-1:0]            rom_addr
);

   localparam int SLOT_IW = $clog2(NUM_SLOTS);
   localparam int CPU_AW  = SLOT_AW + SLOT_IW;

   if (PAGE_W + SLOT_AW > 31) begin : g_bad_span
      $error("cbm_xlate: ROM span too wide");
   end

   logic [PAGE_W-1:0] page;

   assign slot = cpu_addr[CPU_AW-1 -: SLOT_IW];

   always_comb begin
      page = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (slot == SLOT_IW'(i)) page = page_flat[i*PAGE_W +: PAGE_W];
      end
   end

   assign rom_addr = {page, cpu_addr[SLOT_AW-1:0]};

endmodule

// File: rtl/cbm_select.sv
module cbm_select
   import cbm_pkg::*;
#(
   parameter int SLOT_IW   = 3,
   parameter int SRAM_SLOT = 4
) (
   input  logic               cpu_as,
   input  logic               cpu_we,
   input  logic [SLOT_IW-1:0] slot,
   input  cbm_ctrl_t          ctrl,
   output logic               rom_cs,
   output logic               sram_cs,
   output logic               sram_we
);

   if (SRAM_SLOT < 1 || SRAM_SLOT >= (1 << SLOT_IW)) begin : g_bad_sram_slot
      $error("cbm_select: SRAM_SLOT must be a paged slot");
   end

   cbm_region_e region;

   always_comb begin
      if (!cpu_as)
         region = RGN_IDLE;
      else if (ctrl.ram_en && slot == SLOT_IW'(SRAM_SLOT))
         region = RGN_SRAM;
      else if (cpu_we)
         region = RGN_DROP;
      else
         region = RGN_ROM;
   end

   assign rom_cs  = (region == RGN_ROM);
   assign sram_cs = (region == RGN_SRAM);
   assign sram_we = sram_cs && cpu_we && !ctrl.wprot;

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cbm_pkg::*;
#(
   parameter int         PAGE_W       = 6,
   parameter int         NUM_SLOTS    = 8,
   parameter int         SLOT_AW      = 18,
   parameter int         SRAM_AW      = 15,
   parameter int         SRAM_SLOT    = 4,
   parameter logic [7:0] REG_BASE     = 8'hF1,
   parameter bit         HAS_PAGING   = 1'b1,
   parameter bit         HAS_WPROTECT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        io_wr,
   input  logic [7:0]  io_ofs,
   input  logic [7:0]  io_data,
   input  logic        cpu_as,
   input  logic        cpu_we,
   input  logic [20:0] cpu_addr,
   output logic [23:0] rom_addr,
   output logic        rom_cs,
   output logic [14:0] sram_addr,
   output logic        sram_cs,
   output logic        sram_we
);

   localparam int SLOT_IW = $clog2(NUM_SLOTS);
   localparam int CPU_AW  = SLOT_AW + SLOT_IW;
   localparam int ROM_AW  = PAGE_W + SLOT_AW;

   if (CPU_AW != 21 || ROM_AW != 24 || SRAM_AW != 15) begin : g_bad_ports
      $error("cart_bank_mapper: parameters do not match the port widths");
   end
   if (SRAM_AW > SLOT_AW) begin : g_bad_sram
      $error("cart_bank_mapper: SRAM larger than one slot");
   end

   cbm_ctrl_t                   ctrl;
   logic [NUM_SLOTS*PAGE_W-1:0] page_flat;
   logic [SLOT_IW-1:0]          slot;

   cbm_regs #(
      .PAGE_W       (PAGE_W),
      .NUM_SLOTS    (NUM_SLOTS),
      .REG_BASE     (REG_BASE),
      .HAS_PAGING   (HAS_PAGING),
      .HAS_WPROTECT (HAS_WPROTECT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_wr     (io_wr),
      .io_ofs    (io_ofs),
      .io_data   (io_data),
      .ctrl      (ctrl),
      .page_flat (page_flat)
   );

   cbm_xlate #(
      .PAGE_W    (PAGE_W),
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_AW   (SLOT_AW)
   ) u_xlate (
      .cpu_addr  (cpu_addr),
      .page_flat (page_flat),
      .slot      (slot),
      .rom_addr  (rom_addr)
   );

   cbm_select #(
      .SLOT_IW   (SLOT_IW),
      .SRAM_SLOT (SRAM_SLOT)
   ) u_select (
      .cpu_as  (cpu_as),
      .cpu_we  (cpu_we),
      .slot    (slot),
      .ctrl    (ctrl),
      .rom_cs  (rom_cs),
      .sram_cs (sram_cs),
      .sram_we (sram_we)
   );

   assign sram_addr = cpu_addr[SRAM_AW-1:0];

   // R6: protect bit set means no SRAM write strobe, whatever the access
   a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_as && cpu_we && ctrl.wprot) |-> !sram_we);

   // R5: the two chip selects never overlap
   a_r5_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_cs && sram_cs));

   // R8: a write outside the enabled save-RAM slot selects nothing
   a_r8_rom_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_as && cpu_we && !sram_cs) |-> !rom_cs);

   // R4: the lowest slot always lands in ROM page 0
   a_r4_slot0_page0: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[20:18] == 3'd0) |-> (rom_addr[23:18] == 6'd0));

endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_ofs = '0;
   logic [7:0]  io_data = '0;
   logic        cpu_as = 1'b0;
   logic        cpu_we = 1'b0;
   logic [20:0] cpu_addr = '0;
   logic [23:0] rom_addr;
   logic        rom_cs;
   logic [14:0] sram_addr;
   logic        sram_cs;
   logic        sram_we;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   cart_bank_mapper uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_wr     (io_wr),
      .io_ofs    (io_ofs),
      .io_data   (io_data),
      .cpu_as    (cpu_as),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .rom_addr  (rom_addr),
      .rom_cs    (rom_cs),
      .sram_addr (sram_addr),
      .sram_cs   (sram_cs),
      .sram_we   (sram_we)
   );

   // CPU byte address and expected ROM byte address after the page setup
   localparam int NV = 8;
   localparam logic [23:0] T_CPU [NV] = '{
      24'h000000, 24'h07FFFE, 24'h080000, 24'h0FFFFE,
      24'h123456, 24'h180010, 24'h3C0000, 24'h300000 };
   localparam logic [24:0] T_ROM [NV] = '{
      25'h0000000, 25'h007FFFE, 25'h1F80000, 25'h1FFFFFE,
      25'h02A3456, 25'h0180010, 25'h1040000, 25'h0300000 };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] ofs, input logic [7:0] data);
      @(negedge clk);
      io_wr = 1'b1; io_ofs = ofs; io_data = data;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic access(input logic as, input logic we, input logic [23:0] byte_addr);
      @(negedge clk);
      cpu_as = as; cpu_we = we; cpu_addr = byte_addr[21:1];
      #2;
   endtask

   function automatic logic [31:0] rom_word(input logic [24:0] byte_addr);
      return {8'h0, byte_addr[24:1]};
   endfunction

   initial begin
      #(200_000 * 20);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      access(1'b0, 1'b0, 24'h000000);
      check("R1 idle rom_cs", 32'(rom_cs), 0);
      check("R1 idle sram_cs", 32'(sram_cs), 0);
      access(1'b1, 1'b0, 24'h200000);
      check("R1 slot4 rom_cs", 32'(rom_cs), 1);
      check("R1 slot4 sram_cs", 32'(sram_cs), 0);
      check("R1 slot4 page4", 32'(rom_addr), rom_word(25'h0200000));
      access(1'b1, 1'b0, 24'h2A0000);
      check("R1 slot5 page5", 32'(rom_addr), rom_word(25'h02A0000));
      access(1'b1, 1'b0, 24'h0FFFFE);
      check("R1 slot1 page1", 32'(rom_addr), rom_word(25'h00FFFFE));

      // R3 setup: slot1 <- 0x3F, slot2 <- 0x05, slot7 <- 0x20
      reg_write(8'hF3, 8'h3F);
      reg_write(8'hF5, 8'h05);
      reg_write(8'hFF, 8'h20);

      // R3 / R4: table walk of translations
      for (int i = 0; i < NV; i++) begin
         access(1'b1, 1'b0, T_CPU[i]);
         check($sformatf("R4 xlate vec%0d rom_addr", i), 32'(rom_addr), rom_word(T_ROM[i]));
         check($sformatf("R3 xlate vec%0d rom_cs", i), 32'(rom_cs), 1);
      end

      // R3: only low six data bits are kept (0xE7 -> page 0x27)
      reg_write(8'hF7, 8'hE7);
      access(1'b1, 1'b0, 24'h180010);
      check("R3 upper data bits dropped", 32'(rom_addr), rom_word(25'h1380010));

      // R7: stray offsets change nothing
      reg_write(8'hF2, 8'h01);
      reg_write(8'hF0, 8'h03);
      reg_write(8'hE1, 8'h03);
      reg_write(8'h01, 8'h00);
      reg_write(8'hF4, 8'h00);
      access(1'b1, 1'b0, 24'h0FFFFE);
      check("R7 slot1 page kept", 32'(rom_addr), rom_word(25'h1FFFFFE));
      access(1'b1, 1'b0, 24'h200000);
      check("R7 ctrl kept rom_cs", 32'(rom_cs), 1);
      check("R7 ctrl kept sram_cs", 32'(sram_cs), 0);

      // R8: write into ROM space selects nothing
      access(1'b1, 1'b1, 24'h000100);
      check("R8 rom write rom_cs", 32'(rom_cs), 0);
      check("R8 rom write sram_cs", 32'(sram_cs), 0);
      check("R8 rom write sram_we", 32'(sram_we), 0);

      // R2 / R5: enable save-RAM
      reg_write(8'hF1, 8'h01);
      access(1'b1, 1'b0, 24'h200010);
      check("R5 sram read sram_cs", 32'(sram_cs), 1);
      check("R5 sram read rom_cs", 32'(rom_cs), 0);
      check("R5 sram read sram_addr", 32'(sram_addr), 32'h0008);
      check("R5 sram read sram_we", 32'(sram_we), 0);
      access(1'b1, 1'b1, 24'h27FFFE);
      check("R2 enable write sram_we", 32'(sram_we), 1);
      check("R5 sram_addr top", 32'(sram_addr), 32'h7FFF);
      access(1'b1, 1'b0, 24'h280000);
      check("R5 slot5 stays rom", 32'(rom_cs), 1);

      // R6: protect set
      reg_write(8'hF1, 8'h03);
      access(1'b1, 1'b1, 24'h200020);
      check("R6 protected write sram_cs", 32'(sram_cs), 1);
      check("R6 protected write sram_we", 32'(sram_we), 0);
      access(1'b1, 1'b0, 24'h200020);
      check("R6 protected read sram_cs", 32'(sram_cs), 1);

      // R9: protect cleared in the same cycle as an SRAM write
      @(negedge clk);
      io_wr = 1'b1; io_ofs = 8'hF1; io_data = 8'h01;
      cpu_as = 1'b1; cpu_we = 1'b1; cpu_addr = 21'(24'h200020 >> 1);
      #2;
      check("R9 old protect applies", 32'(sram_we), 0);
      @(posedge clk); #2;
      check("R9 new protect applies", 32'(sram_we), 1);
      @(negedge clk) io_wr = 1'b0;

      // R9: slot2 page rewritten in the same cycle as a slot2 read
      @(negedge clk);
      io_wr = 1'b1; io_ofs = 8'hF5; io_data = 8'h0A;
      cpu_as = 1'b1; cpu_we = 1'b0; cpu_addr = 21'(24'h100000 >> 1);
      #2;
      check("R9 old page applies", 32'(rom_addr), rom_word(25'h0280000));
      @(posedge clk); #2;
      check("R9 new page applies", 32'(rom_addr), rom_word(25'h0500000));
      @(negedge clk) io_wr = 1'b0;

      // R2: only bits 1..0 matter (0xFC clears both)
      reg_write(8'hF1, 8'hFC);
      access(1'b1, 1'b0, 24'h200000);
      check("R2 high bits ignored rom_cs", 32'(rom_cs), 1);
      check("R2 high bits ignored sram_cs", 32'(sram_cs), 0);

      // R1: reset mid-run restores identity map
      reg_write(8'hF1, 8'h01);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      access(1'b1, 1'b0, 24'h080000);
      check("R1 rerun slot1 identity", 32'(rom_addr), rom_word(25'h0080000));
      access(1'b1, 1'b0, 24'h200000);
      check("R1 rerun sram disabled", 32'(rom_cs), 1);
      access(1'b1, 1'b1, 24'h200000);
      check("R1 rerun no sram_we", 32'(sram_we), 0);

      @(negedge clk) cpu_as = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule